// File: doc/BRIEF.md
# Prioritised Up/Down Modulo Counter

This block is a small binary counter that wraps around in both directions. Three control inputs are decoded in a fixed order of precedence. A synchronous clear, active low, forces the count to zero and overrides everything else. An active-low run input comes next: while it is high the count is frozen. The direction input is looked at only when neither of those applies. With direction 0 the counter steps up, and with direction 1 it steps down.

The design is a Moore machine. A priority decoder picks one of three sources for the next state: the clear value, the present value, or the stepped value. A multiplexer applies that choice, and a register holds the result. The count output is driven straight from that register, so every effect of the controls appears one rising edge after they are sampled.

The width defaults to 2 bits (modulo 4) and is a parameter. The stepping logic can be built either as one shared adder or as a separate incrementer and decrementer followed by a select.

Top module: `prio_updown_counter`

## Requirements
- R1: When `clr_n` is 0 at a rising edge, `count` is 0 after that edge, whatever the present count.
- R2: `clr_n`=0 takes precedence over the other controls: the clear happens for every value of `run_n` and `dir_dn`.
- R3: When `clr_n`=1 and `run_n`=1, `count` keeps its value across the edge, and `dir_dn` has no effect.
- R4: When `clr_n`=1, `run_n`=0 and `dir_dn`=0, `count` increases by 1 at the edge.
- R5: When `clr_n`=1, `run_n`=0 and `dir_dn`=1, `count` decreases by 1 at the edge.
- R6: Counting up from the largest value (3 for 2 bits) gives 0.
- R7: Counting down from 0 gives the largest value (3 for 2 bits).
- R8: `count` is the registered state, with codes 0..3 standing for the states. It changes only at a rising edge of `clk`.
- R9: The clear is synchronous. Dropping `clr_n` between two edges leaves `count` unchanged until the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| clr_n | input | 1 | Synchronous clear, active low, highest precedence |
| run_n | input | 1 | Count enable, active low; 1 holds the count |
| dir_dn | input | 1 | Direction: 0 up, 1 down |
| count | output | WIDTH | Present count (registered state) |

## Verification
Every control setting is sampled at one rising edge, and its result is due on `count` exactly one edge later. The bench drives inputs on the falling edge and pushes the expected count into a queue at that moment. A monitor wakes shortly after the following rising edge, pops one entry and compares it, so each expectation is checked in the one cycle where it is due. For R9 the bench also samples `count` between the edges, right after lowering `clr_n`, to confirm that nothing moves before the edge.

// File: rtl/updn_pkg.sv
package updn_pkg;
   typedef enum logic [1:0] {
      PICK_CLEAR = 2'd0,
      PICK_KEEP  = 2'd1,
      PICK_STEP  = 2'd2
   } pick_t;

   localparam int STEP_SHARED = 0;
   localparam int STEP_SPLIT  = 1;
endpackage

// File: rtl/updn_prio_decode.sv
module updn_prio_decode
   import updn_pkg::*;
(
   input  logic  clr_n,
   input  logic  run_n,
   output pick_t pick
);
   // Precedence: clear, then hold, then step
   always_comb begin
      if (!clr_n)
         pick = PICK_CLEAR;
      else if (run_n)
         pick = PICK_KEEP;
      else
         pick = PICK_STEP;
   end
endmodule

// File: rtl/updn_step_unit.sv
module updn_step_unit
   import updn_pkg::*;
#(
   parameter int WIDTH = 2,
   parameter int STYLE = STEP_SHARED
) (
   input  logic [WIDTH-1:0] cur,
   input  logic             dir_dn,
   output logic [WIDTH-1:0] nxt
);
   localparam logic [WIDTH-1:0] ONE  = WIDTH'(1);
   localparam logic [WIDTH-1:0] ONES = {WIDTH{1'b1}};

   if (WIDTH < 1) begin : g_bad_width
      $error("updn_step_unit: WIDTH must be at least 1");
   end

   if (STYLE == STEP_SHARED) begin : g_shared
      // One adder: adding all-ones subtracts one modulo 2^WIDTH
      logic [WIDTH-1:0] addend;
      always_comb begin
         addend = dir_dn ? ONES : ONE;
         nxt    = cur + addend;
      end
   end else if (STYLE == STEP_SPLIT) begin : g_split
      logic [WIDTH-1:0] inc_v;
      logic [WIDTH-1:0] dec_v;
      always_comb begin
         inc_v = cur + ONE;
         dec_v = cur - ONE;
         nxt   = dir_dn ? dec_v : inc_v;
      end
   end else begin : g_bad_style
      $error("updn_step_unit: unknown STYLE");
   end
endmodule

// File: rtl/updn_next_mux.sv
module updn_next_mux
   import updn_pkg::*;
#(
   parameter int               WIDTH     = 2,
   parameter logic [WIDTH-1:0] CLEAR_VAL = '0
) (
   input  pick_t            pick,
   input  logic [WIDTH-1:0] cur,
   input  logic [WIDTH-1:0] stepped,
   output logic [WIDTH-1:0] nxt
);
   always_comb begin
      unique case (pick)
         PICK_CLEAR: nxt = CLEAR_VAL;
         PICK_KEEP:  nxt = cur;
         PICK_STEP:  nxt = stepped;
         default:    nxt = CLEAR_VAL;
      endcase
   end
endmodule

// File: rtl/updn_state_reg.sv
module updn_state_reg #(
   parameter int WIDTH = 2
) (
   input  logic             clk,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   always_ff @(posedge clk) begin
      q <= d;
   end
endmodule

// File: rtl/prio_updown_counter.sv
module prio_updown_counter
   import updn_pkg::*;
#(
   parameter int WIDTH      = 2,
   parameter int STEP_STYLE = STEP_SHARED
) (
   input  logic             clk,
   input  logic             clr_n,
   input  logic             run_n,
   input  logic             dir_dn,
   output logic [WIDTH-1:0] count
);
   localparam logic [WIDTH-1:0] CLEAR_VAL = '0;

   if (WIDTH < 1 || WIDTH > 32) begin : g_bad_width
      $error("prio_updown_counter: WIDTH out of range 1..32");
   end
   if (STEP_STYLE != STEP_SHARED && STEP_STYLE != STEP_SPLIT) begin : g_bad_style
      $error("prio_updown_counter: STEP_STYLE invalid");
   end

   pick_t            pick;
   logic [WIDTH-1:0] state_q;
   logic [WIDTH-1:0] stepped;
   logic [WIDTH-1:0] state_d;

   updn_prio_decode u_dec (
      .clr_n (clr_n),
      .run_n (run_n),
      .pick  (pick)
   );

   updn_step_unit #(.WIDTH(WIDTH), .STYLE(STEP_STYLE)) u_step (
      .cur    (state_q),
      .dir_dn (dir_dn),
      .nxt    (stepped)
   );

   updn_next_mux #(.WIDTH(WIDTH), .CLEAR_VAL(CLEAR_VAL)) u_mux (
      .pick    (pick),
      .cur     (state_q),
      .stepped (stepped),
      .nxt     (state_d)
   );

   updn_state_reg #(.WIDTH(WIDTH)) u_reg (
      .clk (clk),
      .d   (state_d),
      .q   (state_q)
   );

   // Moore output: the state itself
   assign count = state_q;
endmodule

// File: rtl/updn_counter_chk.sv
module updn_counter_chk #(
   parameter int WIDTH = 2
) (
   input logic             clk,
   input logic             clr_n,
   input logic             run_n,
   input logic             dir_dn,
   input logic [WIDTH-1:0] count
);
   localparam logic [WIDTH-1:0] TOP = {WIDTH{1'b1}};

   // The state is known only once a clear has been seen
   logic armed = 1'b0;
   always_ff @(posedge clk) begin
      if (!clr_n) armed <= 1'b1;
   end

   p_clear_r1: assert property (@(posedge clk) disable iff (!armed)
      !clr_n |=> (count == '0));

   p_clear_wins_r2: assert property (@(posedge clk) disable iff (!armed)
      (!clr_n && !run_n) |=> (count == '0));

   p_hold_r3: assert property (@(posedge clk) disable iff (!armed)
      (clr_n && run_n) |=> $stable(count));

   p_up_r4: assert property (@(posedge clk) disable iff (!armed)
      (clr_n && !run_n && !dir_dn) |=> (count == WIDTH'($past(count) + 1'b1)));

   p_down_r5: assert property (@(posedge clk) disable iff (!armed)
      (clr_n && !run_n && dir_dn) |=> (count == WIDTH'($past(count) - 1'b1)));

   p_wrap_up_r6: assert property (@(posedge clk) disable iff (!armed)
      (clr_n && !run_n && !dir_dn && count == TOP) |=> (count == '0));

   p_wrap_down_r7: assert property (@(posedge clk) disable iff (!armed)
      (clr_n && !run_n && dir_dn && count == '0) |=> (count == TOP));
endmodule

bind prio_updown_counter updn_counter_chk #(.WIDTH(WIDTH)) u_chk (
   .clk    (clk),
   .clr_n  (clr_n),
   .run_n  (run_n),
   .dir_dn (dir_dn),
   .count  (count)
);

// File: tb/sim_prio_updown_counter.sv
module sim_prio_updown_counter;
   localparam int CLK_PERIOD = 10;
   localparam int W          = 2;
   localparam int MODV       = 1 << W;

   typedef struct {
      logic [W-1:0] exp;
      string        tag;
   } item_t;

   logic         clk = 1'b0;
   logic         clr_n = 1'b1;
   logic         run_n = 1'b1;
   logic         dir_dn = 1'b0;
   logic [W-1:0] count;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;
   int model  = 0;
   item_t q[$];

   prio_updown_counter #(.WIDTH(W)) u0 (
      .clk(clk), .clr_n(clr_n), .run_n(run_n), .dir_dn(dir_dn), .count(count)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic check(input logic [W-1:0] act, input logic [W-1:0] exp, input string tag);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: count=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // Driver: set controls on the falling edge, push the value due after the next rising edge
   task automatic apply(input bit c, input bit r, input bit d);
      item_t it;
      string tag;
      @(negedge clk);
      clr_n = c; run_n = r; dir_dn = d;
      if (!c) begin
         tag = (r == 1'b0) ? "R2 clear over run" : "R1 clear";
         model = 0;
      end else if (r) begin
         tag = "R3 hold";
      end else if (!d) begin
         tag = (model == MODV-1) ? "R6 wrap up" : "R4 up";
         model = (model + 1) % MODV;
      end else begin
         tag = (model == 0) ? "R7 wrap down" : "R5 down";
         model = (model + MODV - 1) % MODV;
      end
      it.exp = W'(model);
      it.tag = tag;
      q.push_back(it);
   endtask

   // Monitor: compare one expectation just after each rising edge
   always @(posedge clk) begin
      #1;
      if (q.size() > 0) begin
         item_t it;
         it = q.pop_front();
         check(count, it.exp, {it.tag, " R8"});
      end
   end

   task automatic goto_state(input int s);
      apply(1'b0, 1'b1, 1'b1);
      for (int k = 0; k < s; k++) apply(1'b1, 1'b0, 1'b0);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   initial begin
      // Reset state (R1): clear from the unknown power-up value
      apply(1'b0, 1'b0, 1'b0);
      // Every control combination from every state
      for (int s = 0; s < MODV; s++) begin
         for (int combo = 0; combo < 8; combo++) begin
            goto_state(s);
            apply(combo[2], combo[1], combo[0]);
         end
      end
      // Long runs in both directions (R4..R7)
      goto_state(0);
      for (int k = 0; k < 9; k++) apply(1'b1, 1'b0, 1'b0);
      for (int k = 0; k < 9; k++) apply(1'b1, 1'b0, 1'b1);
      // R3: toggling direction while held changes nothing
      for (int k = 0; k < 4; k++) apply(1'b1, 1'b1, k[0]);
      // R9: clear is synchronous; count must not move between edges
      goto_state(2);
      @(posedge clk); #2;
      @(negedge clk);
      clr_n = 1'b0;
      #1;
      check(count, W'(2), "R9 no clear before edge");
      @(posedge clk); #1;
      check(count, W'(0), "R9 clear at edge");
      @(negedge clk);
      clr_n = 1'b1; run_n = 1'b1;
      repeat (2) @(posedge clk);
      #2;
      finish_run();
   end

   initial begin
      #(CLK_PERIOD * 50000);
      errors++;
      $display("FAIL watchdog: run did not end, expected completion");
      finish_run();
   end
endmodule